// File: doc/BRIEF.md
# Configurable-Edge Mesh Neighbour Shifter

This block moves a single bit-plane one position across a square array of processing elements. Each shift command names a direction. Every element then captures the bit held by its neighbour on that side. The whole plane moves in one clock, and the result is held in a register until the next command. The array side is a parameter, with a default of 8, which gives a 64-bit plane.

A run-time edge mode sets how the array boundary behaves. The boundary can be an isolated square with zero fill, a cylinder closed north-south, a cylinder closed east-west, or a torus. It can also be one of two spiral chains. In the east-west spiral the rows form one long ring in row-major order. In the north-south spiral the columns form one long ring in column-major order. A separate enable unlocks the four diagonal directions, so each element can reach eight neighbours. The element logic and the local memory are outside this block. The caller supplies the source plane on every command.

Top module: `meshShiftNet`

## Requirements
- R1: While rstN is low, and after it is released until the first shift, planeOut is all zeros.
- R2: When shiftEn is low, planeOut keeps its value at the clock edge.
- R3: Bit r*DIM+c is the element at row r and column c. Row 0 is the north edge and column 0 is the west edge. The cardinal dirSel codes are 0 for N, 2 for E, 4 for S and 6 for W. A command with code N loads element (r,c) from source (r-1,c), and E, S and W follow likewise from (r,c+1), (r+1,c) and (r,c-1).
- R4: With edgeMode 0 (open), an element whose source lies outside the array receives 0.
- R5: With edgeMode 1, rows wrap (row -1 is row DIM-1 and row DIM is row 0), and the east and west edges are open.
- R6: With edgeMode 2, columns wrap, and the north and south edges are open.
- R7: With edgeMode 3, both axes wrap (torus), so no bit is lost or created.
- R8: With edgeMode 4, horizontal moves follow the row-major ring. Under W, element (r,0) takes (r-1,DIM-1), and element (0,0) takes (DIM-1,DIM-1). The north and south edges are open.
- R9: With edgeMode 5, vertical moves follow the column-major ring. Under N, element (0,c) takes (DIM-1,c-1), and element (0,0) takes (DIM-1,DIM-1). The east and west edges are open.
- R10: edgeMode values 6 and 7 behave as the open mode.
- R11: With diagEn high, the odd dirSel codes 1 (NE), 3 (SE), 5 (SW) and 7 (NW) combine one row step and one column step. Each step follows the edge rule of its own axis. In a spiral mode the step along the spiral axis is taken first.
- R12: With diagEn low, a shift command with an odd dirSel code leaves planeOut unchanged.
- R13: The shifted plane appears on planeOut at the same clock edge that samples the shift command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| shiftEn | input | 1 | Shift command strobe |
| dirSel | input | 3 | Direction code (N, NE, E, SE, S, SW, W, NW as 0 to 7) |
| edgeMode | input | 3 | Boundary topology select |
| diagEn | input | 1 | Enables the diagonal direction codes |
| planeIn | input | DIM*DIM | Source bit-plane |
| planeOut | output | DIM*DIM | Registered shifted bit-plane |

## Verification
The hardest cases to reach are the two corner hand-offs of the spiral modes combined with a diagonal move. There, the spiral-axis step crosses into the next row or column while the other axis falls off an open edge. A plane with a single set bit only hits these cases when the bit sits exactly in a corner element. The stimulus therefore walks a single one-hot bit through all four corners and every edge midpoint, under every mode and all eight directions. Random dense planes follow to cover the interior and the mixed cases.

// File: rtl/meshShiftPkg.sv
package meshShiftPkg;
  // decoded command for the datapath
  typedef struct packed {
    logic capture;
    logic north;
    logic south;
    logic east;
    logic west;
    logic wrapNs;
    logic wrapEw;
    logic spiralEw;
    logic spiralNs;
  } meshCtrl_t;

  typedef enum logic [2:0] {
    EDGE_OPEN   = 3'd0,
    EDGE_WRAPNS = 3'd1,
    EDGE_WRAPEW = 3'd2,
    EDGE_TORUS  = 3'd3,
    EDGE_SPIREW = 3'd4,
    EDGE_SPIRNS = 3'd5
  } edgeMode_e;
endpackage

// File: rtl/meshShiftCtrl.sv
module meshShiftCtrl
  import meshShiftPkg::*;
(
  input  logic      shiftEn,
  input  logic [2:0] dirSel,
  input  logic [2:0] edgeMode,
  input  logic      diagEn,
  output meshCtrl_t ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.capture = shiftEn && (!dirSel[0] || diagEn);
    unique case (dirSel)
      3'd0: ctrl.north = 1'b1;
      3'd1: begin ctrl.north = 1'b1; ctrl.east = 1'b1; end
      3'd2: ctrl.east = 1'b1;
      3'd3: begin ctrl.south = 1'b1; ctrl.east = 1'b1; end
      3'd4: ctrl.south = 1'b1;
      3'd5: begin ctrl.south = 1'b1; ctrl.west = 1'b1; end
      3'd6: ctrl.west = 1'b1;
      default: begin ctrl.north = 1'b1; ctrl.west = 1'b1; end
    endcase
    ctrl.wrapNs   = (edgeMode == EDGE_WRAPNS) || (edgeMode == EDGE_TORUS);
    ctrl.wrapEw   = (edgeMode == EDGE_WRAPEW) || (edgeMode == EDGE_TORUS);
    ctrl.spiralEw = (edgeMode == EDGE_SPIREW);
    ctrl.spiralNs = (edgeMode == EDGE_SPIRNS);
  end
endmodule

// File: rtl/meshShiftPath.sv
module meshShiftPath
  import meshShiftPkg::*;
#(
  parameter int DIM = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  meshCtrl_t           ctrl,
  input  logic [DIM*DIM-1:0]  planeIn,
  output logic [DIM*DIM-1:0]  planeOut
);
  localparam int NB = DIM * DIM;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  function automatic logic pickBit(input logic [NB-1:0] src, input int r,
                                   input int c, input meshCtrl_t k);
    int dr, dc, sr, sc, lin;
    logic ok;
    dr = k.north ? -1 : (k.south ? 1 : 0);
    dc = k.west ? -1 : (k.east ? 1 : 0);
    ok = 1'b1;
    if (k.spiralEw) begin
      lin = r * DIM + c + dc;
      if (lin < 0) lin = lin + NB;
      else if (lin >= NB) lin = lin - NB;
      sr = lin / DIM + dr;
      sc = lin % DIM;
      if (sr < 0 || sr >= DIM) ok = 1'b0;
    end else if (k.spiralNs) begin
      lin = c * DIM + r + dr;
      if (lin < 0) lin = lin + NB;
      else if (lin >= NB) lin = lin - NB;
      sc = lin / DIM + dc;
      sr = lin % DIM;
      if (sc < 0 || sc >= DIM) ok = 1'b0;
    end else begin
      sr = r + dr;
      sc = c + dc;
      if (sr < 0 || sr >= DIM) begin
        if (k.wrapNs) sr = (sr < 0) ? sr + DIM : sr - DIM;
        else ok = 1'b0;
      end
      if (sc < 0 || sc >= DIM) begin
        if (k.wrapEw) sc = (sc < 0) ? sc + DIM : sc - DIM;
        else ok = 1'b0;
      end
    end
    lin = ok ? (sr * DIM + sc) : 0;
    return ok ? src[lin[IW-1:0]] : 1'b0;
  endfunction

  logic [NB-1:0] nextPlane;

  for (genvar gr = 0; gr < DIM; gr++) begin : g_row
    for (genvar gc = 0; gc < DIM; gc++) begin : g_col
      always_comb nextPlane[gr*DIM+gc] = pickBit(planeIn, gr, gc, ctrl);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             planeOut <= '0;
    else if (ctrl.capture) planeOut <= nextPlane;
  end
endmodule

// File: rtl/meshShiftNet.sv
module meshShiftNet
  import meshShiftPkg::*;
#(
  parameter int DIM = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               shiftEn,
  input  logic [2:0]         dirSel,
  input  logic [2:0]         edgeMode,
  input  logic               diagEn,
  input  logic [DIM*DIM-1:0] planeIn,
  output logic [DIM*DIM-1:0] planeOut
);
  meshCtrl_t ctrl;

  meshShiftCtrl u_ctrl (
    .shiftEn(shiftEn), .dirSel(dirSel), .edgeMode(edgeMode),
    .diagEn(diagEn), .ctrl(ctrl)
  );

  meshShiftPath #(.DIM(DIM)) u_path (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .planeIn(planeIn), .planeOut(planeOut)
  );
endmodule

// File: rtl/meshShiftChk.sv
module meshShiftChk #(
  parameter int DIM = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               shiftEn,
  input logic [2:0]         dirSel,
  input logic [2:0]         edgeMode,
  input logic               diagEn,
  input logic [DIM*DIM-1:0] planeIn,
  input logic [DIM*DIM-1:0] planeOut
);
  localparam int NB = DIM * DIM;

  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !shiftEn |=> $stable(planeOut));

  // R12
  diag_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn && !diagEn && dirSel[0] |=> $stable(planeOut));

  // R4
  open_top_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn && edgeMode == 3'd0 && dirSel == 3'd0 |=> planeOut[DIM-1:0] == '0);

  // R3
  north_body_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn && edgeMode < 3'd4 && dirSel == 3'd0
    |=> planeOut[NB-1:DIM] == $past(planeIn[NB-DIM-1:0]));

  // R7
  torus_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn && edgeMode == 3'd3 && (!dirSel[0] || diagEn)
    |=> $countones(planeOut) == $countones($past(planeIn)));

  // R8
  spiral_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn && edgeMode == 3'd4 && dirSel == 3'd6
    |=> planeOut == {$past(planeIn[NB-2:0]), $past(planeIn[NB-1])});
endmodule

bind meshShiftNet meshShiftChk #(.DIM(DIM)) u_chk (
  .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .dirSel(dirSel),
  .edgeMode(edgeMode), .diagEn(diagEn), .planeIn(planeIn), .planeOut(planeOut)
);

// File: tb/meshShiftNet_bench.sv
`timescale 1ns/1ps
module meshShiftNet_bench;
  localparam int DIM = 8;
  localparam int NB = DIM * DIM;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic shiftEn = 1'b0;
  logic [2:0] dirSel = '0;
  logic [2:0] edgeMode = '0;
  logic diagEn = 1'b0;
  logic [NB-1:0] planeIn = '0;
  logic [NB-1:0] planeOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [NB-1:0] expect_q;

  always #2 clk = ~clk;

  meshShiftNet #(.DIM(DIM)) u_meshShiftNet (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .dirSel(dirSel),
    .edgeMode(edgeMode), .diagEn(diagEn), .planeIn(planeIn), .planeOut(planeOut)
  );

  // reference: returns the value an element at (r,c) receives
  function automatic bit refBit(logic [NB-1:0] p, int r, int c, int d, int m);
    int rowStep[8] = '{-1, -1, 0, 1, 1, 1, 0, -1};
    int colStep[8] = '{0, 1, 1, 1, 0, -1, -1, -1};
    int ring[$];
    int dy, dx, pos, hit, y, x;
    dy = rowStep[d];
    dx = colStep[d];
    if (m == 4 || m == 5) begin
      // ring of element indices along the spiral axis
      for (int a = 0; a < DIM; a++)
        for (int b = 0; b < DIM; b++)
          ring.push_back(m == 4 ? a * DIM + b : b * DIM + a);
      pos = (m == 4) ? r * DIM + c : c * DIM + r;
      pos = (pos + (m == 4 ? dx : dy) + NB) % NB;
      hit = ring[pos];
      y = hit / DIM + (m == 4 ? dy : 0);
      x = hit % DIM + (m == 5 ? dx : 0);
      if (y < 0 || y >= DIM || x < 0 || x >= DIM) return 1'b0;
      return p[y * DIM + x];
    end
    y = r + dy;
    x = c + dx;
    if (m == 1 || m == 3) y = (y + DIM) % DIM;
    if (m == 2 || m == 3) x = (x + DIM) % DIM;
    if (y < 0 || y >= DIM || x < 0 || x >= DIM) return 1'b0;
    return p[y * DIM + x];
  endfunction

  function automatic string tagFor(int en, int d, int m, int dg);
    if (!en) return "R2";
    if (d % 2 == 1 && !dg) return "R12";
    if (d % 2 == 1) return "R11";
    case (m)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      5: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [NB-1:0] got, logic [NB-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one command; output compared one edge later (R13)
  task automatic step(int en, int d, int m, int dg, logic [NB-1:0] p);
    logic [NB-1:0] nxt;
    @(negedge clk);
    shiftEn = en[0];
    dirSel = d[2:0];
    edgeMode = m[2:0];
    diagEn = dg[0];
    planeIn = p;
    nxt = expect_q;
    if (en != 0 && (d % 2 == 0 || dg != 0))
      for (int r = 0; r < DIM; r++)
        for (int c = 0; c < DIM; c++)
          nxt[r * DIM + c] = refBit(p, r, c, d, m);
    @(posedge clk);
    expect_q = nxt;
    @(negedge clk);
    check(tagFor(en, d, m, dg), planeOut, expect_q);
    shiftEn = 1'b0;
  endtask

  function automatic logic [NB-1:0] oneHot(int r, int c);
    logic [NB-1:0] v = '0;
    v[r * DIM + c] = 1'b1;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] v;
    int pts[9][2] = '{'{0,0},'{0,7},'{7,0},'{7,7},'{0,3},'{7,4},'{3,0},'{4,7},'{3,4}};
    expect_q = '0;
    planeIn = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", planeOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", planeOut, '0);

    // R3 directed: element (2,3) seen at (3,3) after N, (1,3) after S
    step(1, 0, 0, 0, oneHot(2, 3));
    check("R3", planeOut, oneHot(3, 3));
    step(1, 4, 0, 0, oneHot(2, 3));
    check("R3", planeOut, oneHot(1, 3));
    // R8 corner: (7,7) enters (0,0) under W
    step(1, 6, 4, 0, oneHot(7, 7));
    check("R8", planeOut, oneHot(0, 0));
    // R9 corner: (7,2) enters (0,3) under N
    step(1, 0, 5, 0, oneHot(7, 2));
    check("R9", planeOut, oneHot(0, 3));
    // R12: diagonal blocked keeps previous value
    step(1, 3, 3, 0, '1);
    check("R12", planeOut, oneHot(0, 3));
    // R2: idle with new data
    step(0, 2, 0, 1, '1);

    // one-hot walk through corners and edges, every mode and direction
    for (int m = 0; m < 8; m++)
      for (int d = 0; d < 8; d++)
        for (int k = 0; k < 9; k++)
          step(1, d, m, 1, oneHot(pts[k][0], pts[k][1]));

    // random dense planes, including idle and blocked cycles
    for (int i = 0; i < 600; i++) begin
      v = {$urandom, $urandom};
      step(($urandom % 5) != 0, $urandom % 8, $urandom % 8, $urandom % 2, v);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule